// File: doc/BRIEF.md
# Floating-Point Division Result Fixup

This unit finishes a floating-point divide. An iterative or table-based divider upstream produces an estimated quotient. This block then takes that estimate together with the original numerator and denominator. It checks the operand pair for NaNs, zeros and infinities in a fixed priority order. When a special case matches, it substitutes the correct special result. When none matches, it forwards the estimate untouched. One parameter selects single (32-bit) or double (64-bit) precision. The decision logic is the same in both formats.

A second parameter selects how the result is delivered. With the register off, the result is combinational. With the register on, there is one cycle of latency, and a valid flag travels with the data. The block does not compute quotients, apply rounding modes, flush denormals or raise exception flags. Denormal operands count as finite and non-zero.

Top module: `fdiv_fixup`

## Requirements
- R1: When the denominator is NaN and the numerator is not NaN, the result is the denominator with its mantissa MSB set, keeping its sign and the rest of its payload.
- R2: When the numerator is NaN, the result is the numerator with its mantissa MSB set, keeping its sign and payload. This applies whatever the denominator is.
- R3: When both the denominator and the numerator are zero, the result is the positive default NaN. A zero is exponent and mantissa all zero, and the sign is ignored. The default NaN is 0x7FC00000 in single precision and 0x7FF8000000000000 in double precision.
- R4: When both the denominator and the numerator are infinite, the result is the default NaN with the sign bit set: 0xFFC00000 or 0xFFF8000000000000.
- R5: When only the denominator is zero, the result is infinity. Its sign is the XOR of the denominator and numerator sign bits.
- R6: When only the denominator is infinite, the result is zero. Its sign is the XOR of the two sign bits.
- R7: When none of R1–R6 applies and the quotient is NaN, the result is infinity carrying the XOR of the denominator and numerator signs.
- R8: In every other case the result equals the quotient bit for bit. This includes denormal operands, and it includes a numerator that is infinite while the denominator is finite and non-zero.
- R9: With the output register enabled, the result and `out_valid` appear on the clock edge after `in_valid` is sampled high. The result holds its value while `in_valid` is low. After reset, `out_valid` is 0.
- R10: A synchronous active-low reset clears `out_valid` and the registered result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| quot_i | input | W | Estimated quotient (W = 32 or 64) |
| den_i | input | W | Denominator |
| num_i | input | W | Numerator |
| out_valid | output | 1 | Result valid |
| result_o | output | W | Fixed-up quotient |

## Verification
The bench targets the priority boundaries. The first is a NaN numerator against a NaN denominator: a design with the top two rows swapped would quiet the wrong payload. The second is 0/0 against inf/inf: a design that mixed these up would return a NaN with the wrong sign. The third is a NaN quotient paired with an infinite or zero denominator: a design that tested the quotient too early would return infinity in place of zero or NaN.

Negative zeros and denormals are also driven. A design that compared zeros including the sign bit, or that treated a denormal as zero, would produce a spurious infinity. The bench also checks signalling-NaN payloads: losing them during quieting shows up as a changed result.

// File: rtl/fdiv_fixup_pkg.sv
// Package: shared types for the division fixup unit.
// Assumes IEEE-754 binary32 or binary64 layouts.
package fdiv_fixup_pkg;
    // Operand class flags produced by the classifier.
    typedef struct packed {
        logic is_nan;
        logic is_inf;
        logic is_zero;
        logic sign;
    } fp_class_t;

    // Which priority row selected the result.
    typedef enum logic [2:0] {
        SEL_DEN_NAN = 3'd0,
        SEL_NUM_NAN = 3'd1,
        SEL_ZZ      = 3'd2,
        SEL_II      = 3'd3,
        SEL_DZERO   = 3'd4,
        SEL_DINF    = 3'd5,
        SEL_QNAN    = 3'd6,
        SEL_PASS    = 3'd7
    } fix_sel_e;
endpackage

// File: rtl/fp_classify.sv
// Module: fp_classify
// Classifies one IEEE-754 value as NaN, infinity or zero, and returns its sign.
// Assumes: the width is 32 or 64; denormals count as finite and non-zero.
module fp_classify
    import fdiv_fixup_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output fp_class_t    cls_o
);
    localparam int EW = (W == 64) ? 11 : 8;
    localparam int MW = W - 1 - EW;

    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;

    // Split the fields and derive the class flags.
    always_comb begin
        exp_f = val_i[W-2 -: EW];
        man_f = val_i[MW-1:0];
        cls_o.sign    = val_i[W-1];
        cls_o.is_nan  = (&exp_f) && (|man_f);
        cls_o.is_inf  = (&exp_f) && !(|man_f);
        cls_o.is_zero = !(|exp_f) && !(|man_f);
    end
endmodule

// File: rtl/fix_priority.sv
// Module: fix_priority
// Picks the special-case row from the operand classes, in fixed priority order.
// Assumes: the classes come from fp_classify.
module fix_priority
    import fdiv_fixup_pkg::*;
(
    input  fp_class_t q_cls,
    input  fp_class_t d_cls,
    input  fp_class_t n_cls,
    output fix_sel_e  sel_o
);
    // The first matching row wins.
    always_comb begin
        if (d_cls.is_nan && !n_cls.is_nan)            sel_o = SEL_DEN_NAN;
        else if (n_cls.is_nan)                        sel_o = SEL_NUM_NAN;
        else if (d_cls.is_zero && n_cls.is_zero)      sel_o = SEL_ZZ;
        else if (d_cls.is_inf && n_cls.is_inf)        sel_o = SEL_II;
        else if (d_cls.is_zero)                       sel_o = SEL_DZERO;
        else if (d_cls.is_inf)                        sel_o = SEL_DINF;
        else if (q_cls.is_nan)                        sel_o = SEL_QNAN;
        else                                          sel_o = SEL_PASS;
    end

    // Immediate checks that the chosen row agrees with the classes.
    always_comb begin
        if (sel_o == SEL_PASS)
            assert_pass_clean_R8: assert (!d_cls.is_nan && !n_cls.is_nan
                && !d_cls.is_zero && !d_cls.is_inf && !q_cls.is_nan);
        if (sel_o == SEL_II)
            assert_ii_inputs_R4: assert (d_cls.is_inf && n_cls.is_inf);
    end
endmodule

// File: rtl/fix_result.sv
// Module: fix_result
// Builds the output word for the selected priority row.
// Assumes: the width is 32 or 64; the sign product is the XOR of the sign bits.
module fix_result
    import fdiv_fixup_pkg::*;
#(
    parameter int W = 32
) (
    input  fix_sel_e     sel_i,
    input  logic [W-1:0] quot_i,
    input  logic [W-1:0] den_i,
    input  logic [W-1:0] num_i,
    output logic [W-1:0] res_o
);
    localparam int EW = (W == 64) ? 11 : 8;
    localparam int MW = W - 1 - EW;
    localparam logic [W-1:0] QBIT  = {{(W-MW){1'b0}}, 1'b1, {(MW-1){1'b0}}};
    localparam logic [W-1:0] INF_P = {1'b0, {EW{1'b1}}, {MW{1'b0}}};
    localparam logic [W-1:0] DNAN  = INF_P | QBIT;

    logic sgn_x;

    // Form the result word from the row and the sign product.
    always_comb begin
        sgn_x = den_i[W-1] ^ num_i[W-1];
        unique case (sel_i)
            SEL_DEN_NAN: res_o = den_i | QBIT;
            SEL_NUM_NAN: res_o = num_i | QBIT;
            SEL_ZZ:      res_o = DNAN;
            SEL_II:      res_o = {1'b1, DNAN[W-2:0]};
            SEL_DZERO,
            SEL_QNAN:    res_o = {sgn_x, INF_P[W-2:0]};
            SEL_DINF:    res_o = {sgn_x, {(W-1){1'b0}}};
            default:     res_o = quot_i;
        endcase
    end
endmodule

// File: rtl/fdiv_fixup.sv
// Module: fdiv_fixup (top)
// Replaces an estimated divide quotient with the IEEE special result when the
// operands call for one. DOUBLE selects binary64; REG_OUT adds one output stage.
// Assumes: synchronous active-low reset; the operands are held while in_valid is high.
module fdiv_fixup
    import fdiv_fixup_pkg::*;
#(
    parameter bit DOUBLE  = 1'b0,
    parameter bit REG_OUT = 1'b1,
    localparam int W = DOUBLE ? 64 : 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] quot_i,
    input  logic [W-1:0] den_i,
    input  logic [W-1:0] num_i,
    output logic         out_valid,
    output logic [W-1:0] result_o
);
    localparam int EW = DOUBLE ? 11 : 8;
    localparam int MW = W - 1 - EW;

    fp_class_t q_cls, d_cls, n_cls;
    fix_sel_e  sel;
    logic [W-1:0] fix_w;

    fp_classify #(.W(W)) u_cls_q (.val_i(quot_i), .cls_o(q_cls));
    fp_classify #(.W(W)) u_cls_d (.val_i(den_i),  .cls_o(d_cls));
    fp_classify #(.W(W)) u_cls_n (.val_i(num_i),  .cls_o(n_cls));

    fix_priority u_prio (.q_cls(q_cls), .d_cls(d_cls), .n_cls(n_cls), .sel_o(sel));

    fix_result #(.W(W)) u_res (
        .sel_i(sel), .quot_i(quot_i), .den_i(den_i), .num_i(num_i), .res_o(fix_w)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic         vld_q;
            logic [W-1:0] res_q;

            // Capture the result when valid; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    res_q <= '0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) res_q <= fix_w;
                end
            end
            assign out_valid = vld_q;
            assign result_o  = res_q;

            assert_valid_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(result_o));
            assert_reset_R10: assert property (@(posedge clk)
                !rst_n |=> (!out_valid && result_o == '0));
            assert_nan_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && d_cls.is_nan) |=> (&result_o[W-2 -: EW]) && result_o[MW-1]);
            assert_ii_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && d_cls.is_inf && n_cls.is_inf) |=> result_o[W-1]);
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result_o  = fix_w;
        end
    endgenerate
endmodule

// File: tb/test_fdiv_fixup.sv
module test_fdiv_fixup;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [W-1:0] quot_i = '0, den_i = '0, num_i = '0;
    logic out_valid;
    logic [W-1:0] result_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdiv_fixup #(.DOUBLE(1'b0), .REG_OUT(1'b1)) i_fdiv_fixup (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .quot_i(quot_i),
        .den_i(den_i), .num_i(num_i), .out_valid(out_valid), .result_o(result_o)
    );

    function automatic bit isnan(logic [31:0] v); return v[30:23] == 8'hFF && v[22:0] != 0; endfunction
    function automatic bit isinf(logic [31:0] v); return v[30:23] == 8'hFF && v[22:0] == 0; endfunction
    function automatic bit iszero(logic [31:0] v); return v[30:0] == 0; endfunction

    // Behavioural reference written straight from the requirement table.
    function automatic logic [31:0] ref_fix(logic [31:0] q, d, n);
        logic s = d[31] ^ n[31];
        if (isnan(d) && !isnan(n)) return d | 32'h0040_0000;
        if (isnan(n)) return n | 32'h0040_0000;
        if (iszero(d) && iszero(n)) return 32'h7FC0_0000;
        if (isinf(d) && isinf(n)) return 32'hFFC0_0000;
        if (iszero(d)) return {s, 31'h7F80_0000};
        if (isinf(d)) return {s, 31'h0};
        if (isnan(q)) return {s, 31'h7F80_0000};
        return q;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one operand set and check the registered result one cycle later.
    task automatic apply(string req, logic [31:0] q, d, n);
        @(negedge clk);
        quot_i = q; den_i = d; num_i = n; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, {31'b0, out_valid}, 32'd1);
        chk(req, result_o, ref_fix(q, d, n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", {31'b0, out_valid}, 0);
        chk("R10", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", {31'b0, out_valid}, 0);
        apply("R1", 32'h3F80_0000, 32'hFF80_0001, 32'h4000_0000);
        apply("R2", 32'h3F80_0000, 32'h7FA0_0003, 32'hFF81_2345);
        apply("R2", 32'h3F80_0000, 32'h4000_0000, 32'h7F80_0005);
        apply("R3", 32'h3F80_0000, 32'h8000_0000, 32'h0000_0000);
        apply("R4", 32'h3F80_0000, 32'h7F80_0000, 32'hFF80_0000);
        apply("R5", 32'h3F80_0000, 32'h8000_0000, 32'h4000_0000);
        apply("R5", 32'h7FC0_0000, 32'h0000_0000, 32'hC000_0000);
        apply("R6", 32'h7FC0_0000, 32'hFF80_0000, 32'h4000_0000);
        apply("R6", 32'h3F80_0000, 32'h7F80_0000, 32'h4000_0000);
        apply("R7", 32'h7F80_0009, 32'hC000_0000, 32'h4000_0000);
        apply("R8", 32'h3FC0_0000, 32'h4000_0000, 32'h4040_0000);
        apply("R8", 32'h0000_0001, 32'h0000_0001, 32'h0000_0000);
        apply("R8", 32'h7F80_0000, 32'h4000_0000, 32'hFF80_0000);
        // R9: the result holds while in_valid is low.
        quot_i = 32'h1234_5678; den_i = 32'h3F80_0000; num_i = 32'h3F80_0000;
        @(negedge clk);
        chk("R9", {31'b0, out_valid}, 0);
        chk("R9", result_o, ref_fix(32'h7F80_0000, 32'h4000_0000, 32'hFF80_0000));
        // R10: a mid-run reset clears the output.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", result_o, 0);
        rst_n = 1'b1;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule